// File: doc/BRIEF.md
# Prioritized Interrupt Vectoring Controller

This block decides, once per machine cycle, whether one of three interrupt sources should divert the processor: external interrupt 1, the timer 1 overflow and the serial port. The serial port requests when either its transmit-done or its receive-done flag is up. A request needs three things: the global enable, the enable bit of its source and the source's flag. It must also be allowed by the priority level now in service. A low-priority service may be pre-empted only by a source whose priority bit is set. A high-priority service cannot be pre-empted at all.

When it accepts a request, the block waits for the start of the next machine cycle. At that edge it emits a two-byte stack write carrying the current program counter, a stack pointer advanced by two, and a program counter load with the source's vector address. The timer 1 flag is cleared by a hardware pulse. The in-service level is pushed onto a two-entry level history, and a return strobe pops it back. Instruction decode and the peripherals that raise the flags belong to the surrounding core.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset no strobe is active (`stk_we`, `sp_load`, `pc_load` and `flag_clr` are all 0), nothing is pending and the in-service level is idle (00).
- R2: A source is a candidate only when `gen_en`, its bit of `src_en` and its flag are all 1. The serial flag is `ser_tx_done | ser_rx_done`. Source index 0 is external interrupt 1, index 1 is timer 1 and index 2 is serial.
- R3: At level 00 every candidate is eligible. At level 01 only a candidate whose `src_prio` bit is 1 is eligible. At level 11 no candidate is eligible.
- R4: Among eligible sources the lowest index wins: external interrupt 1, then timer 1, then serial.
- R5: The vector loaded on `pc_next` with `pc_load` is 0x0013 for index 0, 0x001B for index 1 and 0x0023 for index 2.
- R6: At vectoring, `stk_addr_lo` = SP+1 carries PC[7:0] and `stk_addr_hi` = SP+2 carries PC[15:8]. `sp_next` = SP+2, with every sum taken modulo 256. PC and SP are the values of `pc_in` and `sp_in` at the vectoring edge.
- R7: A request is accepted at a clock edge where `cyc_start` is 1. Vectoring happens at the next edge where `cyc_start` is 1, however many clocks later that is. The strobes are high for exactly the one clock after that edge, and at no other time.
- R8: On vectoring the in-service level becomes {priority bit of the source, 1}, so it is 01 or 11. The previous level is saved.
- R9: A `ret_strobe` pulse restores the most recently saved level, up to two nesting deep. A return when nothing is saved leaves the level at 00.
- R10: `flag_clr` bit 1 pulses together with `pc_load` when the timer 1 vector is taken. Bits 0 and 2 stay 0, so the external and serial flags are never cleared by this block.
- R11: At most one request is accepted per machine cycle. While an accepted request waits to vector, new requests are ignored, and the vector taken is the one chosen at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start | input | 1 | High for one clock at the start of each machine cycle |
| ret_strobe | input | 1 | Return-from-interrupt pulse |
| gen_en | input | 1 | Global interrupt enable |
| src_en | input | 3 | Per-source enables (0 ext1, 1 timer 1, 2 serial) |
| src_prio | input | 3 | Per-source priority bits, same order |
| ext1_flag | input | 1 | External interrupt 1 request flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| ser_tx_done | input | 1 | Serial transmit-done flag |
| ser_rx_done | input | 1 | Serial receive-done flag |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 8 | Current stack pointer |
| stk_we | output | 1 | Stack write strobe for both bytes |
| stk_addr_lo | output | 8 | Address of the low return byte |
| stk_data_lo | output | 8 | Low return byte |
| stk_addr_hi | output | 8 | Address of the high return byte |
| stk_data_hi | output | 8 | High return byte |
| sp_load | output | 1 | Stack pointer load strobe |
| sp_next | output | 8 | New stack pointer |
| pc_load | output | 1 | Program counter load strobe |
| pc_next | output | 16 | Vector address |
| flag_clr | output | 3 | Hardware flag-clear pulses, one per source |

## Verification
The in-service level has no port of its own. A wrong level therefore shows up only at the next arbitration: a request is taken that should be blocked, or one is refused that should be taken. Either way `pc_load` is wrong one machine cycle after the offending request. A corrupted pending state shows up the same way. Either a vector appears without a new `cyc_start`, or a late request overrides the chosen vector, so `pc_next` or `flag_clr` is wrong at the very vectoring edge. The nesting sequences walk the level through 00, 01 and 11 and back, so that history errors surface through later acceptance decisions.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_PEND = 1'b1
   } ivc_state_e;

   localparam logic [1:0] LVL_IDLE = 2'b00;
   localparam logic [1:0] LVL_LOW  = 2'b01;
   localparam logic [1:0] LVL_HIGH = 2'b11;

   // level entered when a source of the given priority is serviced
   function automatic logic [1:0] svc_level(input logic hi);
      return {hi, 1'b1};
   endfunction

endpackage

// File: rtl/ivc_arb.sv
module ivc_arb #(
   parameter int NSRC  = 3,
   localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gen_en,
   input  logic [NSRC-1:0]  src_en,
   input  logic [NSRC-1:0]  src_req,
   input  logic [NSRC-1:0]  src_prio,
   input  logic [1:0]       lvl,
   output logic [NSRC-1:0]  grant,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   import ivc_pkg::*;

   logic [NSRC-1:0] elig;
   logic [NSRC:0]   taken;

   assign taken[0] = 1'b0;

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      logic cand;
      assign cand        = gen_en & src_en[g] & src_req[g];
      assign elig[g]     = cand & ((lvl == LVL_IDLE) | ((lvl == LVL_LOW) & src_prio[g]));
      assign grant[g]    = elig[g] & ~taken[g];
      assign taken[g+1]  = taken[g] | elig[g];
   end

   assign any = taken[NSRC];

   always_comb begin
      idx = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (grant[i]) idx = IDX_W'(i);
      end
   end

   // high-priority service refuses every request
   p_top_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl == LVL_HIGH) |-> !any);

   // a grant always goes to a requesting source
   p_grant_has_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ((grant & src_req & src_en) != '0) && $onehot0(grant));

endmodule

// File: rtl/ivc_level.sv
module ivc_level #(
   parameter int DEPTH = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push,
   input  logic       push_hi,
   input  logic       pop,
   output logic [1:0] lvl
);
   import ivc_pkg::*;

   logic [1:0] hist [DEPTH];

   initial begin
      assert (DEPTH >= 1) else $error("ivc_level: DEPTH must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl <= LVL_IDLE;
      end else if (push) begin
         lvl <= svc_level(push_hi);
      end else if (pop) begin
         lvl <= hist[0];
      end
   end

   for (genvar d = 0; d < DEPTH; d++) begin : g_hist
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist[d] <= LVL_IDLE;
         end else if (push) begin
            if (d == 0) hist[d] <= lvl;
            else        hist[d] <= hist[(d == 0) ? 0 : d-1];
         end else if (pop) begin
            if (d == DEPTH-1) hist[d] <= LVL_IDLE;
            else              hist[d] <= hist[(d == DEPTH-1) ? d : d+1];
         end
      end
   end

   // the level never takes the unused code
   p_level_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lvl != 2'b10);

   // a return with nothing saved leaves the block idle
   p_pop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && lvl == LVL_IDLE) |=> lvl == LVL_IDLE);

endmodule

// File: rtl/ivc_push.sv
module ivc_push #(
   parameter int            DATA_W    = 8,
   parameter int            SP_W      = 8,
   parameter int            NSRC      = 3,
   parameter int            VEC_FIRST = 'h13,
   parameter int            VEC_STEP  = 8,
   parameter logic [NSRC-1:0] CLR_MASK = '0,
   localparam int           PC_W      = 2 * DATA_W,
   localparam int           IDX_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [IDX_W-1:0]  idx,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [SP_W-1:0]   sp_in,
   output logic              load,
   output logic [SP_W-1:0]   addr_lo,
   output logic [DATA_W-1:0] data_lo,
   output logic [SP_W-1:0]   addr_hi,
   output logic [DATA_W-1:0] data_hi,
   output logic [SP_W-1:0]   sp_next,
   output logic [PC_W-1:0]   pc_next,
   output logic [NSRC-1:0]   clr
);

   logic [NSRC-1:0] sel;
   logic [PC_W-1:0] vec;

   assign sel = NSRC'(1) << idx;
   assign vec = PC_W'(VEC_FIRST) + PC_W'(idx) * PC_W'(VEC_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load    <= 1'b0;
         addr_lo <= '0;
         data_lo <= '0;
         addr_hi <= '0;
         data_hi <= '0;
         sp_next <= '0;
         pc_next <= '0;
         clr     <= '0;
      end else begin
         load <= fire;
         clr  <= fire ? (sel & CLR_MASK) : '0;
         if (fire) begin
            addr_lo <= sp_in + SP_W'(1);
            addr_hi <= sp_in + SP_W'(2);
            sp_next <= sp_in + SP_W'(2);
            data_lo <= pc_in[DATA_W-1:0];
            data_hi <= pc_in[PC_W-1:DATA_W];
            pc_next <= vec;
         end
      end
   end

   // the two stack bytes land in consecutive cells, the upper one at the new top
   p_push_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (sp_next == addr_hi) && (addr_hi == addr_lo + SP_W'(1)));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int DATA_W       = 8,
   parameter int SP_W         = 8,
   parameter int VEC_FIRST    = 'h13,
   parameter int VEC_STEP     = 8,
   parameter int HIST_DEPTH   = 2,
   parameter logic [2:0] HW_CLR_MASK = 3'b010,
   localparam int NSRC        = 3,
   localparam int PC_W        = 2 * DATA_W,
   localparam int IDX_W       = $clog2(NSRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_start,
   input  logic              ret_strobe,
   input  logic              gen_en,
   input  logic [NSRC-1:0]   src_en,
   input  logic [NSRC-1:0]   src_prio,
   input  logic              ext1_flag,
   input  logic              tmr1_flag,
   input  logic              ser_tx_done,
   input  logic              ser_rx_done,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [SP_W-1:0]   sp_in,
   output logic              stk_we,
   output logic [SP_W-1:0]   stk_addr_lo,
   output logic [DATA_W-1:0] stk_data_lo,
   output logic [SP_W-1:0]   stk_addr_hi,
   output logic [DATA_W-1:0] stk_data_hi,
   output logic              sp_load,
   output logic [SP_W-1:0]   sp_next,
   output logic              pc_load,
   output logic [PC_W-1:0]   pc_next,
   output logic [NSRC-1:0]   flag_clr
);
   import ivc_pkg::*;

   initial begin
      assert (DATA_W >= 4) else $error("irq_vector_ctrl: DATA_W too small");
      assert (SP_W >= 2)   else $error("irq_vector_ctrl: SP_W too small");
      assert (VEC_STEP > 0) else $error("irq_vector_ctrl: VEC_STEP must be positive");
      assert (VEC_FIRST + (NSRC-1)*VEC_STEP < 2**PC_W)
         else $error("irq_vector_ctrl: vectors exceed the address range");
   end

   ivc_state_e       state;
   logic [IDX_W-1:0] pend_idx;
   logic             pend_hi;
   logic [1:0]       lvl;
   logic [NSRC-1:0]  src_req;
   logic [NSRC-1:0]  grant;
   logic             any;
   logic [IDX_W-1:0] idx;
   logic             accept;
   logic             exec;
   logic             load;

   assign src_req = {ser_tx_done | ser_rx_done, tmr1_flag, ext1_flag};
   assign accept  = (state == ST_IDLE) & cyc_start & any;
   assign exec    = (state == ST_PEND) & cyc_start;

   ivc_arb #(.NSRC(NSRC)) i_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .gen_en   (gen_en),
      .src_en   (src_en),
      .src_req  (src_req),
      .src_prio (src_prio),
      .lvl      (lvl),
      .grant    (grant),
      .any      (any),
      .idx      (idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pend_idx <= '0;
         pend_hi  <= 1'b0;
      end else if (accept) begin
         state    <= ST_PEND;
         pend_idx <= idx;
         pend_hi  <= |(grant & src_prio);
      end else if (exec) begin
         state    <= ST_IDLE;
      end
   end

   ivc_level #(.DEPTH(HIST_DEPTH)) i_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (exec),
      .push_hi (pend_hi),
      .pop     (ret_strobe & ~exec),
      .lvl     (lvl)
   );

   ivc_push #(
      .DATA_W    (DATA_W),
      .SP_W      (SP_W),
      .NSRC      (NSRC),
      .VEC_FIRST (VEC_FIRST),
      .VEC_STEP  (VEC_STEP),
      .CLR_MASK  (HW_CLR_MASK)
   ) i_push (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (exec),
      .idx     (pend_idx),
      .pc_in   (pc_in),
      .sp_in   (sp_in),
      .load    (load),
      .addr_lo (stk_addr_lo),
      .data_lo (stk_data_lo),
      .addr_hi (stk_addr_hi),
      .data_hi (stk_data_hi),
      .sp_next (sp_next),
      .pc_next (pc_next),
      .clr     (flag_clr)
   );

   assign stk_we  = load;
   assign sp_load = load;
   assign pc_load = load;

   // vectoring only follows a machine-cycle start
   p_vec_on_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> $past(cyc_start));

   // one acceptance, then a pending interval before the next
   p_single_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !accept);

   // hardware clears only travel with a vector load
   p_clr_with_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr != '0) |-> pc_load && $onehot(flag_clr));

   // a vector strobe lasts one clock
   p_load_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> !pc_load);

endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_start = 1'b0;
   logic        ret_strobe = 1'b0;
   logic        gen_en = 1'b0;
   logic [2:0]  src_en = '0;
   logic [2:0]  src_prio = '0;
   logic        ext1_flag = 1'b0;
   logic        tmr1_flag = 1'b0;
   logic        ser_tx_done = 1'b0;
   logic        ser_rx_done = 1'b0;
   logic [15:0] pc_in = '0;
   logic [7:0]  sp_in = '0;
   logic        stk_we;
   logic [7:0]  stk_addr_lo, stk_data_lo, stk_addr_hi, stk_data_hi;
   logic        sp_load;
   logic [7:0]  sp_next;
   logic        pc_load;
   logic [15:0] pc_next;
   logic [2:0]  flag_clr;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_vector_ctrl i_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .ret_strobe(ret_strobe),
      .gen_en(gen_en), .src_en(src_en), .src_prio(src_prio),
      .ext1_flag(ext1_flag), .tmr1_flag(tmr1_flag),
      .ser_tx_done(ser_tx_done), .ser_rx_done(ser_rx_done),
      .pc_in(pc_in), .sp_in(sp_in),
      .stk_we(stk_we), .stk_addr_lo(stk_addr_lo), .stk_data_lo(stk_data_lo),
      .stk_addr_hi(stk_addr_hi), .stk_data_hi(stk_data_hi),
      .sp_load(sp_load), .sp_next(sp_next), .pc_load(pc_load),
      .pc_next(pc_next), .flag_clr(flag_clr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         finish_run();
      end
   end

   task automatic pulse_cyc();
      @(negedge clk) cyc_start = 1'b1;
      @(negedge clk) cyc_start = 1'b0;
   endtask

   task automatic pulse_ret();
      @(negedge clk) ret_strobe = 1'b1;
      @(negedge clk) ret_strobe = 1'b0;
   endtask

   task automatic set_flags(input logic [3:0] f);
      ext1_flag = f[0]; tmr1_flag = f[1]; ser_tx_done = f[2]; ser_rx_done = f[3];
   endtask

   // full vectoring check, outputs sampled on the negedge after the vectoring edge
   task automatic chk_vec(input string tag, input int src, input logic [15:0] pc, input logic [7:0] sp);
      chk({tag, " R7 pc_load"}, pc_load, 1);
      chk({tag, " R6 stk_we"}, stk_we, 1);
      chk({tag, " R6 sp_load"}, sp_load, 1);
      chk({tag, " R5 vector"}, pc_next, 32'h13 + src * 8);
      chk({tag, " R6 addr_lo"}, stk_addr_lo, 8'(sp + 8'd1));
      chk({tag, " R6 addr_hi"}, stk_addr_hi, 8'(sp + 8'd2));
      chk({tag, " R6 sp_next"}, sp_next, 8'(sp + 8'd2));
      chk({tag, " R6 data_lo"}, stk_data_lo, pc[7:0]);
      chk({tag, " R6 data_hi"}, stk_data_hi, pc[15:8]);
      chk({tag, " R10 flag_clr"}, flag_clr, (src == 1) ? 3'b010 : 3'b000);
   endtask

   function automatic int first_of(input logic [2:0] e);
      if (e[0]) return 0;
      if (e[1]) return 1;
      if (e[2]) return 2;
      return -1;
   endfunction

   initial begin
      int src;
      logic [2:0] req, el;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 stk_we", stk_we, 0);
      chk("R1 pc_load", pc_load, 0);
      chk("R1 sp_load", sp_load, 0);
      chk("R1 flag_clr", flag_clr, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle level means a low-priority source is taken at once
      gen_en = 1; src_en = 3'b111; src_prio = 3'b000; set_flags(4'b0001);
      pc_in = 16'h4321; sp_in = 8'h07;
      pulse_cyc(); pulse_cyc();
      chk_vec("R1 idle", 0, 16'h4321, 8'h07);
      pulse_ret();

      // R2 R4 R5 R6 R10: sweep of flags, enables and global enable from level 00
      for (int t = 0; t < 256; t++) begin
         pulse_ret(); pulse_ret();
         set_flags(t[3:0]);
         src_en   = t[6:4];
         gen_en   = t[7];
         src_prio = t[2:0] ^ t[5:3];
         pc_in    = 16'(16'hA000 + t * 16'h0101);
         sp_in    = 8'(t);
         req = {t[2] | t[3], t[1], t[0]};
         el  = req & t[6:4] & {3{t[7]}};
         src = first_of(el);
         pulse_cyc(); pulse_cyc();
         if (src < 0) begin
            chk("R2 no accept pc_load", pc_load, 0);
            chk("R2 no accept stk_we", stk_we, 0);
         end else begin
            chk_vec("R2 R4 sweep", src, pc_in, sp_in);
            @(negedge clk);
            chk("R7 strobe one clock", pc_load, 0);
         end
      end

      // R3 R4: sweep at level 01 (entered through a low-priority ext1 service)
      for (int t = 0; t < 128; t++) begin
         pulse_ret(); pulse_ret();
         gen_en = 1; src_en = 3'b111; src_prio = 3'b000; set_flags(4'b0001);
         pulse_cyc(); pulse_cyc();
         chk("R3 setup low", pc_next, 16'h0013);
         set_flags(t[3:0]);
         src_prio = t[6:4];
         pc_in = 16'(16'h1000 + t);
         sp_in = 8'(8'h80 + t);
         req = {t[2] | t[3], t[1], t[0]};
         src = first_of(req & t[6:4]);
         pulse_cyc(); pulse_cyc();
         if (src < 0) chk("R3 low level blocks", pc_load, 0);
         else chk_vec("R3 R4 low level preempt", src, pc_in, sp_in);
      end
      pulse_ret(); pulse_ret();

      // R8 R9 R3: nesting walk 00 -> 01 -> 11 -> 01 -> 11 -> 01 -> 00
      gen_en = 1; src_en = 3'b111; src_prio = 3'b000; set_flags(4'b0010);
      pc_in = 16'hBEEF; sp_in = 8'h30;
      pulse_cyc(); pulse_cyc();
      chk_vec("R8 low timer", 1, 16'hBEEF, 8'h30);
      set_flags(4'b0001);
      pulse_cyc(); pulse_cyc();
      chk("R8 level 01 refuses low", pc_load, 0);
      src_prio = 3'b100; set_flags(4'b0100);
      pulse_cyc(); pulse_cyc();
      chk_vec("R8 high serial", 2, 16'hBEEF, 8'h30);
      src_prio = 3'b111; set_flags(4'b1111);
      pulse_cyc(); pulse_cyc();
      chk("R3 level 11 refuses all", pc_load, 0);
      set_flags(4'b0000);
      pulse_ret();
      src_prio = 3'b000; set_flags(4'b0001);
      pulse_cyc(); pulse_cyc();
      chk("R9 restored to 01 refuses low", pc_load, 0);
      src_prio = 3'b001;
      pulse_cyc(); pulse_cyc();
      chk_vec("R9 restored to 01 takes high", 0, 16'hBEEF, 8'h30);
      set_flags(4'b0000);
      pulse_ret();
      src_prio = 3'b000; set_flags(4'b0001);
      pulse_cyc(); pulse_cyc();
      chk("R9 second nest back to 01", pc_load, 0);
      set_flags(4'b0000);
      pulse_ret(); pulse_ret();
      set_flags(4'b0001);
      pulse_cyc(); pulse_cyc();
      chk_vec("R9 empty return stays 00", 0, 16'hBEEF, 8'h30);
      set_flags(4'b0000);
      pulse_ret();

      // R7 R11: vectoring waits for the next cycle start, late requests ignored
      src_prio = 3'b000; set_flags(4'b0100);
      pc_in = 16'h0102; sp_in = 8'hFF;
      pulse_cyc();
      set_flags(4'b0011);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R7 no vector before cycle start", pc_load, 0);
      end
      pc_in = 16'h5A6B; sp_in = 8'hFE;
      pulse_cyc();
      chk_vec("R11 pending keeps serial", 2, 16'h5A6B, 8'hFE);
      @(negedge clk);
      chk("R7 pulse ends", pc_load, 0);
      pulse_ret();

      finish_run();
   end

endmodule